// File: doc/BRIEF.md
# Shared Add/Subtract Unit with Signed Overflow Flag

This block adds or subtracts two W-bit two's complement operands on a single chain of full-adder cells. A mode bit picks the operation. When subtracting, each bit of the second operand passes through an inverting 2:1 selector, and the mode bit itself enters the least significant cell as the carry-in. The chain therefore forms A + ~B + 1, which equals A − B.

The block has three outputs: the W-bit result with the top carry dropped, that top carry as a separate unsigned flag, and a signed overflow flag. The overflow flag is set when both effective operands have the same sign and the sum has the opposite sign.

A parameter chooses whether the outputs are combinational or pass through one output register stage. The register stage has an asynchronous active-low reset.

Top module: `addsub_unit`

## Requirements
- R1: With `sub_i` = 0, `res_o` equals (A + B) modulo 2^W.
- R2: With `sub_i` = 1, `res_o` equals (A − B) modulo 2^W.
- R3: During addition, `ovf_o` is 1 exactly when the signed sum lies outside −2^(W−1) .. 2^(W−1)−1. For W = 8 this range is −128 .. 127.
- R4: During subtraction, `ovf_o` is 1 exactly when the signed difference lies outside the same range.
- R5: During addition, `cout_o` is bit W of the unsigned sum. During subtraction, `cout_o` is 1 exactly when A ≥ B taken as unsigned values, that is, when no borrow occurs.
- R6: `ovf_o` stays 0 whenever the effective operands have opposite signs. This covers addition with operands of opposite sign and subtraction with operands of equal sign.
- R7: With `REG_OUT` = 1, the outputs show the result for the inputs present at a rising clock edge from that edge onwards, and do not change between edges. With `REG_OUT` = 0, the outputs follow the inputs with no clock involved.
- R8: With `REG_OUT` = 1, `res_o`, `cout_o` and `ovf_o` are all 0 while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| sub_i | input | 1 | Mode: 0 adds, 1 subtracts |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| res_o | output | W | Result with the top carry dropped |
| cout_o | output | 1 | Carry out of the top cell |
| ovf_o | output | 1 | Signed overflow flag |

## Verification
With the default registered stage, all three results are due one rising edge after the operands and mode are applied. The bench drives the inputs on a falling edge and compares the outputs on the next falling edge, after exactly one capture. One nanosecond after it drives new inputs, it also confirms that the outputs still hold the previous result. A second copy of the block, built at W = 4 with no register stage, is checked for every operand pair in both modes one nanosecond after its inputs change. The checker compares each registered output against its `$past` inputs, so it follows the same single-edge delay.

// File: rtl/addsub_unit.sv
module addsub_unit #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sub_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         cout_o,
  output logic         ovf_o
);
  logic [W-1:0] b_eff, sum;
  logic [W:0]   cy;
  logic         ovf_c;

  assign cy[0] = sub_i;

  for (genvar i = 0; i < W; i++) begin : g_cell
    assign b_eff[i]  = sub_i ? ~b_i[i] : b_i[i];
    assign sum[i]    = a_i[i] ^ b_eff[i] ^ cy[i];
    assign cy[i+1]   = (a_i[i] & b_eff[i]) | (a_i[i] & cy[i]) | (b_eff[i] & cy[i]);
  end

  assign ovf_c = (a_i[W-1] == b_eff[W-1]) && (sum[W-1] != a_i[W-1]);

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_o  <= '0;
        cout_o <= 1'b0;
        ovf_o  <= 1'b0;
      end else begin
        res_o  <= sum;
        cout_o <= cy[W];
        ovf_o  <= ovf_c;
      end
    end
  end else begin : g_comb
    assign res_o  = sum;
    assign cout_o = cy[W];
    assign ovf_o  = ovf_c;
  end
endmodule

// File: rtl/addsub_unit_chk.sv
module addsub_unit_chk #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sub_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] res_o,
  input logic         cout_o,
  input logic         ovf_o
);
  logic [W:0] sx_add, sx_sub, ux_add;
  logic       ov_add, ov_sub, no_borrow, opp;

  assign sx_add    = {a_i[W-1], a_i} + {b_i[W-1], b_i};
  assign sx_sub    = {a_i[W-1], a_i} - {b_i[W-1], b_i};
  assign ux_add    = {1'b0, a_i} + {1'b0, b_i};
  assign ov_add    = sx_add[W] ^ sx_add[W-1];
  assign ov_sub    = sx_sub[W] ^ sx_sub[W-1];
  assign no_borrow = (a_i >= b_i);
  assign opp       = sub_i ? (a_i[W-1] == b_i[W-1]) : (a_i[W-1] != b_i[W-1]);

  if (REG_OUT) begin : g_seq
    p_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !sub_i |=> res_o == $past(sx_add[W-1:0]));
    p_diff_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sub_i |=> res_o == $past(sx_sub[W-1:0]));
    p_ovf_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !sub_i |=> ovf_o == $past(ov_add));
    p_ovf_sub_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sub_i |=> ovf_o == $past(ov_sub));
    p_cout_r5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> cout_o == ($past(sub_i) ? $past(no_borrow) : $past(ux_add[W])));
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      opp |=> !ovf_o);
  end else begin : g_cmb
    p_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !sub_i |-> res_o == sx_add[W-1:0]);
    p_diff_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sub_i |-> res_o == sx_sub[W-1:0]);
    p_ovf_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !sub_i |-> ovf_o == ov_add);
    p_ovf_sub_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sub_i |-> ovf_o == ov_sub);
    p_cout_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cout_o == (sub_i ? no_borrow : ux_add[W]));
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      opp |-> !ovf_o);
  end
endmodule

bind addsub_unit addsub_unit_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/addsub_unit_test.sv
module addsub_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       sub8 = 1'b0;
  logic [7:0] a8 = '0, b8 = '0, r8;
  logic       c8, v8;
  logic       sub4 = 1'b0;
  logic [3:0] a4 = '0, b4 = '0, r4;
  logic       c4, v4;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  addsub_unit #(.W(8), .REG_OUT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .sub_i(sub8), .a_i(a8), .b_i(b8),
    .res_o(r8), .cout_o(c8), .ovf_o(v8));

  addsub_unit #(.W(4), .REG_OUT(1'b0)) uut_n4 (
    .clk(clk), .rst_n(rst_n), .sub_i(sub4), .a_i(a4), .b_i(b4),
    .res_o(r4), .cout_o(c4), .ovf_o(v4));

  function automatic void model(input int w, input bit sub, input int a, input int b,
                                output int r, output bit co, output bit ov);
    int sa, sb, ex, lim;
    lim = 1 << (w - 1);
    sa  = (a >= lim) ? a - 2 * lim : a;
    sb  = (b >= lim) ? b - 2 * lim : b;
    ex  = sub ? sa - sb : sa + sb;
    ov  = (ex >= lim) || (ex < -lim);
    r   = (sub ? a - b : a + b) & ((1 << w) - 1);
    co  = sub ? (a >= b) : (((a + b) >> w) & 1) != 0;
  endfunction

  task automatic cmp(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all(input int w, input bit sub, input int a, input int b,
                           input int r, input bit co, input bit ov);
    int er; bit ec, ev, opp;
    int top;
    model(w, sub, a, b, er, ec, ev);
    top = 1 << (w - 1);
    opp = sub ? (((a & top) != 0) == ((b & top) != 0)) : (((a & top) != 0) != ((b & top) != 0));
    cmp(sub ? "R2 result" : "R1 result", r, er);
    cmp("R5 carry", int'(co), int'(ec));
    if (opp) cmp("R6 opposite-sign overflow", int'(ov), 0);
    else     cmp(sub ? "R4 overflow" : "R3 overflow", int'(ov), int'(ev));
  endtask

  task automatic op8(input bit sub, input int a, input int b);
    logic [7:0] prev_r;
    @(negedge clk);
    prev_r = r8;
    sub8 = sub; a8 = a[7:0]; b8 = b[7:0];
    #1 cmp("R7 held between edges", int'(r8), int'(prev_r));
    @(negedge clk);
    check_all(8, sub, a & 8'hFF, b & 8'hFF, int'(r8), c8, v8);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog R7 actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    sub8 = 1'b1; a8 = 8'h7F; b8 = 8'h80;
    repeat (3) @(negedge clk);
    cmp("R8 reset result", int'(r8), 0);
    cmp("R8 reset carry", int'(c8), 0);
    cmp("R8 reset overflow", int'(v8), 0);
    rst_n = 1'b1;

    op8(1'b0, 8'h7F, 8'h01);
    op8(1'b0, 8'h80, 8'hFF);
    op8(1'b0, 8'hFF, 8'h01);
    op8(1'b0, 8'h7F, 8'h80);
    op8(1'b1, 8'h80, 8'h01);
    op8(1'b1, 8'h7F, 8'hFF);
    op8(1'b1, 8'h00, 8'h80);
    op8(1'b1, 8'h80, 8'h80);
    op8(1'b1, 8'h00, 8'h01);
    op8(1'b1, 8'h05, 8'h05);
    for (int i = 0; i < 3000; i++)
      op8(1'($urandom), int'($urandom & 32'hFF), int'($urandom & 32'hFF));

    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          @(negedge clk);
          sub4 = m[0]; a4 = a[3:0]; b4 = b[3:0];
          #1 check_all(4, m[0], a, b, int'(r4), c4, v4);
        end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule